// File: doc/BRIEF.md
# Symmetric PWM Timer Channel

This block is an 8-bit timer with one compare channel that generates a centre-aligned, phase-correct PWM waveform. A selectable prescaler turns the system clock into a count enable. On each enabled cycle the counter steps one place, climbing from 0 to 255 and then falling back to 0. The output level changes where the count meets the active compare value. When the count climbs the meeting point drives the output low, and when it falls the meeting point drives it high, so the high interval is centred on BOTTOM.

Software writes the compare value into a holding register. That value moves into the active compare register only at the top turning point, so a change never splits a period unevenly. At the top turning point the output is also forced to the level a rising match would give. This keeps the waveform symmetric when the compare value leaves 255, and it covers a rising match that was skipped. A sticky flag marks each return to BOTTOM, and a pulse input clears it. An invert input complements the pin.

Top module: `pwm_sym_timer`

## Requirements
- R1: `presc_sel` picks the count-enable rate: 1 gives every cycle, 2 gives one in 8, 3 one in 64, 4 one in 256 and 5 one in 1024. Codes 0, 6 and 7 stop the counter.
- R2: The count changes only on enabled cycles. It climbs one step per enable from 0 to 255 and then falls one step per enable to 0, and this repeats.
- R3: A change of `presc_sel` restarts the divider. With a divide-by-N selection, the first count step comes exactly N cycles after the edge that captured the new code.
- R4: While the active compare value is 0, the non-inverted output stays low.
- R5: While the active compare value is 255, the non-inverted output stays high.
- R6: When the count reaches 255 and the active compare value is below 255, the non-inverted output is low. This holds even when no match occurred, for example after the compare value leaves 255.
- R7: For an active compare value between 1 and 254, a climbing step onto that value drives the non-inverted level low. A falling step onto it drives the level high. Any other step holds the level.
- R8: When `invert` is 1, `wave_o` is the complement of the non-inverted level, in the same cycle and including both constant extremes.
- R9: `cmp_wr` loads `cmp_wdata` into a holding register. The holding value becomes active only on the climbing step that reaches 255. If a write lands on that same cycle, the older held value is the one loaded.
- R10: `ovf_o` goes to 1 on the falling step that reaches 0. It stays at 1 until a cycle with `flag_clr` high clears it. If a set and a clear fall in the same cycle, the set wins.
- R11: A synchronous active-low reset makes the count 0 and climbing, the level low, the flag 0, both compare registers 0 and the divider idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 3 | Divider selection code |
| invert | input | 1 | 1 complements the output pin |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| flag_clr | input | 1 | Clears the BOTTOM flag |
| count_o | output | 8 | Current count |
| wave_o | output | 1 | PWM output |
| ovf_o | output | 1 | Sticky BOTTOM flag |

## Verification
The bench targets four cases: the two constant extremes (compare 0 and 255), the move of the compare value away from 255, and a compare write that lands on the same cycle as the top turning point. A design that got the extremes wrong would emit a one-count glitch at a turning point. One that mishandled leaving 255 would leave the output high for a whole half-period. One that mishandled the same-cycle write would load the new value a period early. Divider restarts on selection changes are also covered, together with set/clear collisions on the flag. An off-by-one restart would shift every later edge by a cycle.

// File: rtl/pcpwm_pkg.sv
// Shared constants and helpers for the symmetric PWM timer.
// Assumes selection codes 1..5 map to the five divide ratios, all others stop.
package pcpwm_pkg;
    localparam int PS_W = 10;

    typedef enum logic [2:0] {
        SEL_STOP   = 3'd0,
        SEL_DIV1   = 3'd1,
        SEL_DIV8   = 3'd2,
        SEL_DIV64  = 3'd3,
        SEL_DIV256 = 3'd4,
        SEL_DIV1K  = 3'd5
    } div_sel_e;

    // Divide ratio for a selection code, 0 meaning stopped.
    function automatic logic [PS_W:0] div_ratio(input logic [2:0] s);
        case (s)
            SEL_DIV1:   div_ratio = (PS_W+1)'(1);
            SEL_DIV8:   div_ratio = (PS_W+1)'(8);
            SEL_DIV64:  div_ratio = (PS_W+1)'(64);
            SEL_DIV256: div_ratio = (PS_W+1)'(256);
            SEL_DIV1K:  div_ratio = (PS_W+1)'(1024);
            default:    div_ratio = '0;
        endcase
    endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
// Count-enable generator. It pulses tick once every N cycles for the selected ratio.
// Assumes sel is synchronous to clk. Any change of sel restarts the divide count.
module pcpwm_prescaler
    import pcpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [2:0]      sel_q;
    logic [PS_W-1:0] div_cnt;
    logic [PS_W:0]   ratio;
    logic            running;

    // Decode the limit and form the enable pulse.
    always_comb begin
        ratio   = div_ratio(sel);
        running = (ratio != '0) && (sel == sel_q);
        tick    = running && (div_cnt == PS_W'(ratio - 1'b1));
    end

    // Track the selection and advance or restart the divide count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= SEL_STOP;
            div_cnt <= '0;
        end else begin
            sel_q <= sel;
            if (!running || tick)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcpwm_updown.sv
// Up/down counter. It climbs to the all-ones value, then falls to zero, one step per tick.
// Assumes tick is a single-cycle enable. It flags the steps that reach each turning point.
module pcpwm_updown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt,
    output logic         step_up,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] TOP = '1;

    logic up_q;

    // Next count and turning-point detection for the pending step.
    always_comb begin
        step_up   = up_q;
        nxt       = up_q ? cnt + 1'b1 : cnt - 1'b1;
        at_top    = tick && up_q && (nxt == TOP);
        at_bottom = tick && !up_q && (nxt == '0);
    end

    // Step the count and reverse direction at the extremes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (tick) begin
            cnt <= nxt;
            if (at_top)
                up_q <= 1'b0;
            else if (at_bottom)
                up_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pcpwm_wave.sv
// Compare buffering and output level. The holding value loads at the top.
// The level follows rising/falling matches, with both constant extremes forced,
// and takes the rising-match level at the top.
module pcpwm_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         step_up,
    input  logic [W-1:0] nxt,
    input  logic         at_top,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         invert,
    output logic         wave,
    output logic [W-1:0] ocr_active
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] hold_q;
    logic [W-1:0] ocr_eff;
    logic         lvl_q;
    logic         lvl_d;

    // Compare value in force for this step, and the resulting level.
    always_comb begin
        ocr_eff = at_top ? hold_q : ocr_active;
        lvl_d   = lvl_q;
        if (tick) begin
            if (ocr_eff == '0)
                lvl_d = 1'b0;
            else if (ocr_eff == TOP)
                lvl_d = 1'b1;
            else if (nxt == TOP)
                lvl_d = 1'b0;
            else if (nxt == ocr_eff)
                lvl_d = !step_up;
        end
    end

    // Holding register, active compare register and level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            ocr_active <= '0;
            lvl_q      <= 1'b0;
        end else begin
            if (cmp_wr)
                hold_q <= cmp_wdata;
            ocr_active <= ocr_eff;
            lvl_q      <= lvl_d;
        end
    end

    // Pin polarity.
    always_comb wave = lvl_q ^ invert;
endmodule

// File: rtl/pwm_sym_timer.sv
// Top of the symmetric PWM timer. It ties the divider, the up/down counter and the
// wave logic together and holds the sticky BOTTOM flag. Everything runs on clk.
module pwm_sym_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       presc_sel,
    input  logic             invert,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             wave_o,
    output logic             ovf_o
);
    logic             tick;
    logic [CNT_W-1:0] nxt;
    logic             step_up;
    logic             at_top;
    logic             at_bottom;
    logic [CNT_W-1:0] ocr_active;

    pcpwm_prescaler u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .tick  (tick)
    );

    pcpwm_updown #(.W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt       (count_o),
        .nxt       (nxt),
        .step_up   (step_up),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    pcpwm_wave #(.W(CNT_W)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .step_up    (step_up),
        .nxt        (nxt),
        .at_top     (at_top),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .invert     (invert),
        .wave       (wave_o),
        .ocr_active (ocr_active)
    );

    // Sticky flag: set on reaching BOTTOM, cleared by pulse, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_o <= 1'b0;
        else if (at_bottom)
            ovf_o <= 1'b1;
        else if (flag_clr)
            ovf_o <= 1'b0;
    end
endmodule

// File: rtl/pcpwm_checker.sv
// Property checker for the symmetric PWM timer, bound into every instance.
// Assumes synchronous active-low reset; all properties are idle while in reset.
module pcpwm_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [W-1:0] count_o,
    input logic         step_up,
    input logic [W-1:0] ocr_active,
    input logic         wave_o,
    input logic         invert,
    input logic         ovf_o
);
    localparam logic [W-1:0] TOP = '1;

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

    p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ocr_active == '0) |-> (wave_o == invert));

    p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ocr_active == TOP) |-> (wave_o == !invert));

    p_top_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == TOP && ocr_active != TOP) |-> (wave_o == invert));

    p_load_at_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ocr_active != $past(ocr_active)) |-> (count_o == TOP));

    p_flag_bottom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !step_up && count_o == W'(1)) |=> ovf_o);
endmodule

bind pwm_sym_timer pcpwm_checker #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .count_o    (count_o),
    .step_up    (step_up),
    .ocr_active (ocr_active),
    .wave_o     (wave_o),
    .invert     (invert),
    .ovf_o      (ovf_o)
);

// File: tb/test_pwm_sym_timer.sv
module test_pwm_sym_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] presc_sel = 3'd0;
    logic       invert = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] count_o;
    logic       wave_o;
    logic       ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag_c = "R2";
    string tag_w = "R7";
    string tag_f = "R10";

    // Reference state, built from the requirements.
    int m_selq, m_pcnt, m_cnt, m_buf, m_ocr;
    bit m_up, m_lvl, m_flag;

    always #2 clk = ~clk;

    pwm_sym_timer i_pwm_sym_timer (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .invert(invert),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
        .count_o(count_o), .wave_o(wave_o), .ovf_o(ovf_o)
    );

    function automatic int ratio_of(input int s);
        case (s)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    // Reference update on each rising edge (R1, R3, R2, R4..R7, R9, R10, R11).
    always @(posedge clk) begin
        int n, nc, oe;
        bit run, tk, up0, top, bot;
        if (!rst_n) begin
            m_selq = 0; m_pcnt = 0; m_cnt = 0; m_up = 1; m_buf = 0;
            m_ocr = 0; m_lvl = 0; m_flag = 0;
        end else begin
            n   = ratio_of(int'(presc_sel));
            run = (n != 0) && (int'(presc_sel) == m_selq);
            tk  = run && (m_pcnt == n - 1);
            m_pcnt = (!run || tk) ? 0 : m_pcnt + 1;
            m_selq = int'(presc_sel);
            bot = 0;
            if (tk) begin
                up0 = m_up;
                nc  = up0 ? m_cnt + 1 : m_cnt - 1;
                top = up0 && nc == 255;
                bot = !up0 && nc == 0;
                oe  = top ? m_buf : m_ocr;
                if (oe == 0) m_lvl = 0;
                else if (oe == 255) m_lvl = 1;
                else if (nc == 255) m_lvl = 0;
                else if (nc == oe) m_lvl = !up0;
                m_ocr = oe;
                m_cnt = nc;
                if (top) m_up = 0;
                else if (bot) m_up = 1;
            end
            if (cmp_wr) m_buf = int'(cmp_wdata);
            if (bot) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs at the falling edge, then clear the strobes.
    task automatic cyc();
        @(negedge clk);
        chk(tag_c, int'(count_o), m_cnt);
        chk(tag_w, int'(wave_o), int'(m_lvl ^ invert));
        chk(tag_f, int'(ovf_o), int'(m_flag));
        cmp_wr = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int v);
        cmp_wr = 1'b1;
        cmp_wdata = 8'(v);
    endtask

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", int'(count_o), 0);
        chk("R11", int'(wave_o), 0);
        chk("R11", int'(ovf_o), 0);
        rst_n = 1'b1;
        // R1 / R2 / R7 / R9: divide-by-1, mid compare
        tag_c = "R1"; presc_sel = 3'd1; wr(100);
        tag_c = "R2"; run(1200);
        // R10: clear pulses, with one collision at BOTTOM
        tag_f = "R10"; flag_clr = 1'b1; run(10);
        while (!(m_cnt == 1 && !m_up)) cyc();
        flag_clr = 1'b1; run(3);
        // R4: compare 0 holds low
        tag_w = "R4"; wr(0); run(1100);
        // R5: compare 255 holds high, also inverted (R8)
        tag_w = "R5"; wr(255); run(700);
        tag_w = "R8"; invert = 1'b1; run(600); invert = 1'b0;
        // R6: leave 255 toward a mid value, level at the top
        tag_w = "R6"; wr(40); run(1100);
        // R9: write landing on the cycle of the top step
        tag_w = "R9";
        while (!(m_cnt == 254 && m_up)) cyc();
        wr(200); run(1);
        wr(30); run(1100);
        // R8: inverted mid compare
        tag_w = "R8"; invert = 1'b1; run(600); invert = 1'b0;
        // R3: selection changes restart the divider
        tag_c = "R3"; tag_w = "R7";
        presc_sel = 3'd2; run(50);
        presc_sel = 3'd3; run(200);
        presc_sel = 3'd2; run(13);
        presc_sel = 3'd1; run(5);
        presc_sel = 3'd0; run(20);
        presc_sel = 3'd7; run(20);
        tag_c = "R1"; presc_sel = 3'd4; run(1100);
        presc_sel = 3'd5; run(2100);
        // Random segments
        tag_c = "R2"; tag_w = "R7";
        for (int s = 0; s < 24; s++) begin
            case ($urandom_range(0, 5))
                0, 1, 2: presc_sel = 3'd1;
                3: presc_sel = 3'd2;
                4: presc_sel = 3'd0;
                default: presc_sel = 3'd6;
            endcase
            invert = 1'($urandom_range(0, 1));
            for (int i = 0; i < 500; i++) begin
                cyc();
                if ($urandom_range(0, 40) == 0) begin
                    case ($urandom_range(0, 3))
                        0: wr(0);
                        1: wr(255);
                        default: wr(int'($urandom_range(1, 254)));
                    endcase
                end
                if ($urandom_range(0, 60) == 0) flag_clr = 1'b1;
            end
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule